// File: doc/BRIEF.md
# Two-Read Byte-Wide Conversion Result Port

This block sits between a 10-bit successive-approximation converter and a host that reads over an 8-bit bus. When the converter signals end of conversion, the block captures the code. A host access with chip select and read both low then drives one byte: the first access after a conversion gives the eight most significant bits. The next access gives the two least significant bits, placed on the top two bus lines with zeros below. Later accesses keep alternating between these two bytes, and each new conversion starts the sequence again from the upper byte. A host that only wants an 8-bit result reads once per conversion.

All strobes are sampled on the block clock. A read access ends when the read strobe is seen returning high while chip select is still low. That returning edge moves the byte selector on. A read made while the converter is busy is allowed, but it is flagged as stale and shows the previously captured code. The interface is plain strobe control with no valid/ready handshake, because a host read cannot be stalled.

Top module: `dual_byte_result_port`

## Requirements
- R1: `dbus_oe` is high only in cycles where `cs_n` and `rd_n` are both low. In every other cycle `dbus_oe` is low and `dbus` is all zeros.
- R2: The first read after a conversion returns code bits [9:2] on `dbus[7:0]`, in straight binary.
- R3: The second read returns code bits [1:0] on `dbus[7:6]`, with `dbus[5:0]` zero.
- R4: Further reads alternate between the upper byte (R2) and the lower byte (R3).
- R5: A rising `busy` returns the byte selector to the upper byte, even if only one byte was read since the last conversion.
- R6: `code` is captured only in a cycle where `eoc` is high. Changes on `code` at any other time do not affect the bytes read.
- R7: A read while `busy` is high raises `rd_stale`. It presents the previously captured result and does not move the byte selector.
- R8: The byte selector moves only when `rd_n` is seen rising while `cs_n` is low and `busy` is low. A read strobe pulse with `cs_n` high moves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy | input | 1 | High while a conversion is in progress |
| eoc | input | 1 | One-cycle end-of-conversion strobe that captures `code` |
| code | input | 10 | Conversion result, straight binary |
| dbus | output | 8 | Data byte; zero when not enabled |
| dbus_oe | output | 1 | Output enable for the external tri-state bus driver |
| rd_stale | output | 1 | The current access falls while `busy` is high, so the data is invalid |

## Verification
The hardest case to reach is a read that overlaps a running conversion. That read must show the old code, must be flagged as stale, and must leave the selector at the upper byte for the first read after the conversion ends. The stimulus therefore splits a conversion into separate start and finish tasks and issues full read accesses between them. It also drives read pulses with chip select high and changes `code` outside the `eoc` cycle. The bytes read afterwards then reveal any selector movement or capture that should not have happened.

// File: rtl/result_port_pkg.sv
package result_port_pkg;
  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/port_edge_sense.sv
module port_edge_sense #(
  parameter int          N    = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= INIT[i];
      else        last_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~last_q;
  end
endmodule

// File: rtl/port_result_hold.sv
module port_result_hold #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoc,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] res
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res <= '0;
    else if (eoc) res <= code;
  end

  // R6: capture on the eoc strobe, otherwise hold
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> res == $past(code));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> $stable(res));
endmodule

// File: rtl/port_byte_ptr.sv
module port_byte_ptr
  import result_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy_rise,
  input  logic      rd_done,
  output byte_sel_e sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel <= SEL_UPPER;
    else if (busy_rise) sel <= SEL_UPPER;
    else if (rd_done)   sel <= (sel == SEL_UPPER) ? SEL_LOWER : SEL_UPPER;
  end

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rise |=> sel == SEL_UPPER);
  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !busy_rise) |=> sel != $past(sel));
  assert_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done && !busy_rise) |=> $stable(sel));
endmodule

// File: rtl/dual_byte_result_port.sv
module dual_byte_result_port
  import result_port_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              busy,
  input  logic              eoc,
  input  logic [CODE_W-1:0] code,
  output logic [BUS_W-1:0]  dbus,
  output logic              dbus_oe,
  output logic              rd_stale
);
  localparam int LO_W  = CODE_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [1:0]        rise;
  logic              rd_rise, busy_rise, rd_done;
  logic [CODE_W-1:0] res;
  byte_sel_e         sel;
  logic [BUS_W-1:0]  hi_byte, lo_byte;

  // index 0: rd_n (idles high), index 1: busy (idles low)
  port_edge_sense #(.N(2), .INIT(2'b01)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl({busy, rd_n}), .rise(rise)
  );
  assign rd_rise   = rise[0];
  assign busy_rise = rise[1];
  assign rd_done   = rd_rise & ~cs_n & ~busy;

  port_result_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .eoc(eoc), .code(code), .res(res)
  );

  port_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .busy_rise(busy_rise), .rd_done(rd_done), .sel(sel)
  );

  assign hi_byte = res[CODE_W-1:LO_W];
  if (PAD_W > 0) begin : g_pad
    assign lo_byte = {res[LO_W-1:0], {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign lo_byte = res[BUS_W-1:0];
  end

  assign dbus_oe  = ~cs_n & ~rd_n;
  assign rd_stale = dbus_oe & busy;
  always_comb begin
    dbus = '0;
    if (dbus_oe) dbus = (sel == SEL_LOWER) ? lo_byte : hi_byte;
  end

  assert_bus_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!dbus_oe && dbus == '0));
  assert_stale_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && busy) |-> rd_stale);
  assert_lower_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && sel == SEL_LOWER) |-> dbus[PAD_W-1:0] == '0);
endmodule

// File: tb/dual_byte_result_port_bench.sv
module dual_byte_result_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, busy = 1'b0, eoc = 1'b0;
  logic [9:0] code = '0;
  logic [7:0] dbus;
  logic       dbus_oe, rd_stale;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] d; logic st; logic [3:0] req; } exp_t;
  exp_t q[$];
  logic probe = 1'b0;

  logic [9:0] m_res = '0;
  bit         m_lower = 0;

  always #2 clk = ~clk;

  dual_byte_result_port u_dual_byte_result_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .eoc(eoc), .code(code), .dbus(dbus), .dbus_oe(dbus_oe), .rd_stale(rd_stale)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected item for each probed access
  always @(negedge clk) begin
    if (probe) begin
      exp_t e;
      e = q.pop_front();
      check($sformatf("R%0d data", e.req), {2'b00, dbus}, {2'b00, e.d});
      check("R1 oe during read", {9'd0, dbus_oe}, 10'd1);
      check("R7 stale flag", {9'd0, rd_stale}, {9'd0, e.st});
    end
  end

  task automatic host_read(input logic [3:0] req);
    exp_t e;
    e.d   = m_lower ? {m_res[1:0], 6'b0} : m_res[9:2];
    e.st  = busy;
    e.req = req;
    @(posedge clk); #1;
    cs_n = 0; rd_n = 0; q.push_back(e); probe = 1;
    @(posedge clk); #1;
    probe = 0; rd_n = 1;
    @(posedge clk); #1;
    cs_n = 1;
    if (!busy) m_lower = !m_lower;
  endtask

  task automatic conv_start();
    @(posedge clk); #1;
    busy = 1;
    m_lower = 0;
    @(posedge clk); #1;
  endtask

  task automatic conv_finish(input logic [9:0] c);
    @(posedge clk); #1;
    busy = 0; eoc = 1; code = c;
    @(posedge clk); #1;
    eoc = 0; code = ~c;   // later changes must be ignored (R6)
    m_res = c;
  endtask

  task automatic convert(input logic [9:0] c);
    conv_start();
    repeat (3) @(posedge clk);
    conv_finish(c);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset oe", {9'd0, dbus_oe}, 10'd0);
    check("R1 reset bus", {2'b0, dbus}, 10'd0);

    // R2 R3 R4: full-scale, zero and mixed codes
    convert(10'h3FF);
    host_read(4'd2); host_read(4'd3); host_read(4'd4); host_read(4'd4);
    convert(10'h000);
    host_read(4'd2); host_read(4'd3);
    convert(10'h2A5);
    host_read(4'd2); host_read(4'd3); host_read(4'd4);

    // R5: single read, then new conversion restarts at upper byte
    convert(10'h15A);
    host_read(4'd2);
    convert(10'h0C3);
    host_read(4'd5); host_read(4'd3);

    // R8: read pulse with cs high neither drives nor advances
    @(posedge clk); #1 rd_n = 0;
    @(negedge clk);
    check("R1 cs high oe", {9'd0, dbus_oe}, 10'd0);
    check("R1 cs high bus", {2'b0, dbus}, 10'd0);
    @(posedge clk); #1 rd_n = 1;
    @(posedge clk);
    host_read(4'd8);   // expects upper byte, selector unmoved

    // R6: code wiggled outside eoc, read shows captured value
    @(posedge clk); #1 code = 10'h1E7;
    @(posedge clk); #1 code = 10'h001;
    host_read(4'd6); host_read(4'd6);

    // R7: reads during busy are stale, old data, selector frozen
    convert(10'h2F0);
    host_read(4'd2);
    conv_start();
    host_read(4'd7); host_read(4'd7);
    conv_finish(10'h10F);
    host_read(4'd7); host_read(4'd3);

    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule